// File: doc/BRIEF.md
# Packed 16-bit SIMD Add/Subtract Unit

This execution unit operates on two register operands split into 16-bit lanes. A 64-bit datapath has four lanes, and lane 0 occupies bits 15:0. A small decoder reads the opcode, funct3 and funct7 fields of an instruction. From them it chooses two things. The first is the lane pattern: straight add, straight subtract, a crossed pair or a straight pair. The second is the arithmetic flavour: wrap-around, signed halving, unsigned halving, signed saturating or unsigned saturating. The unit registers its result one cycle after an operation is presented.

The pair patterns act separately on each 32-bit pair of lanes: lanes 0/1, lanes 2/3 and so on. In a crossed pair, each half takes its second operand from the other half of the same pair in the second source. Two outputs are one-cycle pulses that accompany the result. The saturation-set pulse tells a status register to set its sticky flag. The illegal pulse reports an encoding that the unit does not recognise.

The unit has no internal state machine. Its only state is the output register, which holds its value while the unit is idle.

Top module: `simd16_addsub`

## Requirements
- R1: An operation is recognised only when opcode is 7'b1111111 and one of two conditions holds. Either funct3 is 3'b000 with funct7[6:2] in {01000, 00000, 00100, 00010, 00110}, or funct3 is 3'b010 with funct7[1]=1 and funct7[6:2] in {11110, 10110, 11010, 11000, 11100}. Any other encoding gives a zero result, raises `illegal` and leaves `sat_set` low.
- R2: Wrap flavour (funct7[6:2] 01000 / 11110) keeps the low 16 bits of each lane's sum or difference. No carry or borrow crosses a lane boundary, and `sat_set` stays low.
- R3: Signed halving (00000 / 10110) forms the 17-bit signed sum or difference and shifts it right arithmetically by one, rounding toward negative infinity. `sat_set` stays low.
- R4: Unsigned halving (00100 / 11010) forms the 17-bit unsigned result, keeping the carry or borrow bit, and shifts it right logically by one. As a result, 0 − 1 yields 0xFFFF.
- R5: Signed saturation (00010 / 11000) clamps each lane to the range 0x8000..0x7FFF. `sat_set` pulses exactly when at least one lane clamps.
- R6: Unsigned saturation (00110 / 11100) clamps each lane to the range 0x0000..0xFFFF. `sat_set` pulses exactly when at least one lane clamps.
- R7: With funct3 000, funct7[1:0] selects the lane pattern: 00 add, 01 subtract, 10 crossed add/sub, 11 crossed sub/add. Crossed add/sub gives lo = a.lo − b.hi and hi = a.hi + b.lo. Crossed sub/add gives lo = a.lo + b.hi and hi = a.hi − b.lo.
- R8: With funct3 010, funct7[0]=0 gives lo = a.lo − b.lo and hi = a.hi + b.hi. funct7[0]=1 gives lo = a.lo + b.lo and hi = a.hi − b.hi.
- R9: Each 32-bit lane pair is computed independently of the other pairs.
- R10: `result` and `res_valid` appear on the cycle after `op_valid`. `sat_set` and `illegal` are single-cycle pulses. While `op_valid` is low, `result` holds its value and all three flags are low.
- R11: While reset is held, `result` is zero and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 7 | Major opcode field |
| funct3 | input | 3 | funct3 field |
| funct7 | input | 7 | funct7 field |
| src_a | input | XLEN | First packed operand |
| src_b | input | XLEN | Second packed operand |
| res_valid | output | 1 | Result register was loaded last cycle |
| result | output | XLEN | Packed result |
| sat_set | output | 1 | Pulse: at least one lane clamped |
| illegal | output | 1 | Pulse: unrecognised encoding |

## Verification
Some properties are checked on every cycle:
- the one-cycle latency;
- the quiet, value-holding idle behaviour;
- the zero result with no saturation on an illegal encoding;
- the absence of a saturation pulse under the wrap and signed-halving encodings.

Other behaviour can only be shown by the bench's scenarios, because it depends on lane values:
- the lane arithmetic itself;
- floor rounding on negative odd sums;
- the borrow kept by unsigned halving subtract;
- the clamp values;
- the operand swap in crossed pairs;
- the isolation of lanes and pairs.

// File: rtl/simd16_pkg.sv
`timescale 1ns/1ps
package simd16_pkg;
    localparam int LANE_W = 16;

    typedef enum logic [2:0] {
        K_ADD,
        K_SUB,
        K_CROSS_AS,
        K_CROSS_SA,
        K_STR_AS,
        K_STR_SA
    } kind_e;

    typedef enum logic [2:0] {
        F_WRAP,
        F_SHALF,
        F_UHALF,
        F_SSAT,
        F_USAT
    } flav_e;
endpackage

// File: rtl/simd16_decode.sv
`timescale 1ns/1ps
module simd16_decode
    import simd16_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output logic       legal,
    output kind_e      kind,
    output flav_e      flav
);
    localparam logic [6:0] OPC_PACKED = 7'b1111111;

    always_comb begin
        legal = 1'b0;
        kind  = K_ADD;
        flav  = F_WRAP;
        if (opcode == OPC_PACKED) begin
            if (funct3 == 3'b000) begin
                legal = 1'b1;
                unique case (funct7[6:2])
                    5'b01000: flav = F_WRAP;
                    5'b00000: flav = F_SHALF;
                    5'b00100: flav = F_UHALF;
                    5'b00010: flav = F_SSAT;
                    5'b00110: flav = F_USAT;
                    default:  legal = 1'b0;
                endcase
                unique case (funct7[1:0])
                    2'b00: kind = K_ADD;
                    2'b01: kind = K_SUB;
                    2'b10: kind = K_CROSS_AS;
                    2'b11: kind = K_CROSS_SA;
                endcase
            end else if (funct3 == 3'b010 && funct7[1]) begin
                legal = 1'b1;
                unique case (funct7[6:2])
                    5'b11110: flav = F_WRAP;
                    5'b10110: flav = F_SHALF;
                    5'b11010: flav = F_UHALF;
                    5'b11000: flav = F_SSAT;
                    5'b11100: flav = F_USAT;
                    default:  legal = 1'b0;
                endcase
                kind = funct7[0] ? K_STR_SA : K_STR_AS;
            end
        end
    end
endmodule

// File: rtl/simd16_lane.sv
`timescale 1ns/1ps
module simd16_lane
    import simd16_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  flav_e        flav,
    output logic [W-1:0] res,
    output logic         clamp
);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic         is_signed;
    logic [W:0]   ax, bx, s;
    logic         s_ovf;

    always_comb begin
        is_signed = (flav == F_SHALF) || (flav == F_SSAT);
        ax = {is_signed & a[W-1], a};
        bx = {is_signed & b[W-1], b};
        s  = do_sub ? (ax - bx) : (ax + bx);
        s_ovf = s[W] ^ s[W-1];
        res   = s[W-1:0];
        clamp = 1'b0;
        unique case (flav)
            F_WRAP:  res = s[W-1:0];
            F_SHALF,
            F_UHALF: res = s[W:1];
            F_SSAT: begin
                clamp = s_ovf;
                if (s_ovf) res = s[W] ? S_MIN : S_MAX;
            end
            F_USAT: begin
                clamp = s[W];
                if (s[W]) res = do_sub ? '0 : '1;
            end
            default: res = s[W-1:0];
        endcase
    end
endmodule

// File: rtl/simd16_addsub.sv
`timescale 1ns/1ps
module simd16_addsub
    import simd16_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [6:0]      opcode,
    input  logic [2:0]      funct3,
    input  logic [6:0]      funct7,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            res_valid,
    output logic [XLEN-1:0] result,
    output logic            sat_set,
    output logic            illegal
);
    localparam int W     = LANE_W;
    localparam int LANES = XLEN / W;

    logic             legal;
    kind_e            kind;
    flav_e            flav;
    logic [XLEN-1:0]  lane_res;
    logic [LANES-1:0] lane_clamp;
    logic             crossed;

    logic [XLEN-1:0]  result_d;
    logic             sat_d, ill_d;

    simd16_decode u_dec (
        .opcode (opcode),
        .funct3 (funct3),
        .funct7 (funct7),
        .legal  (legal),
        .kind   (kind),
        .flav   (flav)
    );

    assign crossed = (kind == K_CROSS_AS) || (kind == K_CROSS_SA);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int  PARTNER = i ^ 1;
        localparam bit  IS_HI   = (i % 2) == 1;
        logic [W-1:0] b_op;
        logic         sub_i;

        always_comb begin
            b_op = crossed ? src_b[PARTNER*W +: W] : src_b[i*W +: W];
            unique case (kind)
                K_ADD:                 sub_i = 1'b0;
                K_SUB:                 sub_i = 1'b1;
                K_CROSS_AS, K_STR_AS:  sub_i = !IS_HI;
                K_CROSS_SA, K_STR_SA:  sub_i = IS_HI;
                default:               sub_i = 1'b0;
            endcase
        end

        simd16_lane #(.W(W)) u_lane (
            .a      (src_a[i*W +: W]),
            .b      (b_op),
            .do_sub (sub_i),
            .flav   (flav),
            .res    (lane_res[i*W +: W]),
            .clamp  (lane_clamp[i])
        );
    end

    // next-value process
    always_comb begin
        result_d = result;
        sat_d    = 1'b0;
        ill_d    = 1'b0;
        if (op_valid) begin
            result_d = legal ? lane_res : '0;
            sat_d    = legal && (|lane_clamp);
            ill_d    = !legal;
        end
    end

    // output register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
            sat_set   <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            res_valid <= op_valid;
            result    <= result_d;
            sat_set   <= sat_d;
            illegal   <= ill_d;
        end
    end
endmodule

// File: rtl/simd16_addsub_chk.sv
`timescale 1ns/1ps
module simd16_addsub_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [6:0]      opcode,
    input logic [2:0]      funct3,
    input logic [6:0]      funct7,
    input logic            res_valid,
    input logic [XLEN-1:0] result,
    input logic            sat_set,
    input logic            illegal
);
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !sat_set && !illegal && $stable(result)));

    p_illegal_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0 && !sat_set && res_valid));

    p_wrap_no_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 7'b1111111 && funct3 == 3'b000 && funct7 == 7'b0100000)
        |=> (!sat_set && !illegal));

    p_shalf_no_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 7'b1111111 && funct3 == 3'b000 && funct7 == 7'b0000000)
        |=> (!sat_set && !illegal));

    p_sat_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sat_set |-> (res_valid && !illegal));
endmodule

bind simd16_addsub simd16_addsub_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .funct3    (funct3),
    .funct7    (funct7),
    .res_valid (res_valid),
    .result    (result),
    .sat_set   (sat_set),
    .illegal   (illegal)
);

// File: tb/simd16_addsub_test.sv
`timescale 1ns/1ps
module simd16_addsub_test;
    localparam int XLEN = 64;

    typedef struct packed {
        logic [4:0]  req;
        logic [6:0]  opc;
        logic [2:0]  f3;
        logic [6:0]  f7;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        sat;
        logic        ill;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // R2 wrap add, lane 2 carry must not reach lane 3
        '{5'd2, 7'h7F, 3'b000, 7'b0100000, 64'h0001_FFFF_7FFF_1234, 64'h0001_0001_0001_0001, 64'h0002_0000_8000_1235, 1'b0, 1'b0},
        // R2 wrap sub, borrows stay in lane
        '{5'd2, 7'h7F, 3'b000, 7'b0100001, 64'h0000_0005_8000_0003, 64'h0001_0003_0001_0005, 64'hFFFF_0002_7FFF_FFFE, 1'b0, 1'b0},
        // R3 signed halving add, -1 stays -1
        '{5'd3, 7'h7F, 3'b000, 7'b0000000, 64'h8000_7FFF_FFFF_0003, 64'h8000_7FFF_0000_0004, 64'h8000_7FFF_FFFF_0003, 1'b0, 1'b0},
        // R3 signed halving sub, full-range differences
        '{5'd3, 7'h7F, 3'b000, 7'b0000001, 64'h8000_7FFF_0000_0003, 64'h7FFF_8000_0001_0000, 64'h8000_7FFF_FFFF_0001, 1'b0, 1'b0},
        // R4 unsigned halving add keeps carry
        '{5'd4, 7'h7F, 3'b000, 7'b0010000, 64'hFFFF_0001_0003_8000, 64'hFFFF_0000_0004_8000, 64'hFFFF_0000_0003_8000, 1'b0, 1'b0},
        // R4 unsigned halving sub keeps borrow: 0-1 -> FFFF
        '{5'd4, 7'h7F, 3'b000, 7'b0010001, 64'h0000_0000_0005_FFFF, 64'hFFFF_0001_0002_0000, 64'h8000_FFFF_0001_7FFF, 1'b0, 1'b0},
        // R5 signed saturating add, clamps both ways
        '{5'd5, 7'h7F, 3'b000, 7'b0001000, 64'h8000_7FFF_7FFF_0001, 64'hFFFF_0001_8000_0002, 64'h8000_7FFF_FFFF_0003, 1'b1, 1'b0},
        // R5 signed saturating sub, no clamp, no flag
        '{5'd5, 7'h7F, 3'b000, 7'b0001001, 64'h0000_0000_0005_0000, 64'h0000_0000_0007_0001, 64'h0000_0000_FFFE_FFFF, 1'b0, 1'b0},
        // R5 signed saturating sub, low clamp
        '{5'd5, 7'h7F, 3'b000, 7'b0001001, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_8000, 1'b1, 1'b0},
        // R6 unsigned saturating add
        '{5'd6, 7'h7F, 3'b000, 7'b0011000, 64'h0000_0000_FFFF_1000, 64'h0000_0000_0001_2000, 64'h0000_0000_FFFF_3000, 1'b1, 1'b0},
        // R6 unsigned saturating sub floors at zero
        '{5'd6, 7'h7F, 3'b000, 7'b0011001, 64'h0000_0000_0001_0005, 64'h0000_0000_0002_0003, 64'h0000_0000_0000_0002, 1'b1, 1'b0},
        // R7 R9 crossed add/sub wrap, both pairs
        '{5'd7, 7'h7F, 3'b000, 7'b0100010, 64'h0050_0030_0010_0100, 64'h0003_0007_0001_0002, 64'h0057_002D_0012_00FF, 1'b0, 1'b0},
        // R7 R9 crossed sub/add wrap
        '{5'd7, 7'h7F, 3'b000, 7'b0100011, 64'h0050_0030_0010_0100, 64'h0003_0007_0001_0002, 64'h0049_0033_000E_0101, 1'b0, 1'b0},
        // R8 R9 straight add/sub wrap
        '{5'd8, 7'h7F, 3'b010, 7'b1111010, 64'h0050_0030_0010_0100, 64'h0003_0007_0001_0002, 64'h0053_0029_0011_00FE, 1'b0, 1'b0},
        // R8 R9 straight sub/add wrap
        '{5'd8, 7'h7F, 3'b010, 7'b1111011, 64'h0050_0030_0010_0100, 64'h0003_0007_0001_0002, 64'h004D_0037_000F_0102, 1'b0, 1'b0},
        // R7 crossed signed saturating, both halves clamp
        '{5'd7, 7'h7F, 3'b000, 7'b0001010, 64'h0000_0000_7FFF_8000, 64'h0000_0000_0001_0001, 64'h0000_0000_7FFF_8000, 1'b1, 1'b0},
        // R8 straight unsigned halving sub/add
        '{5'd8, 7'h7F, 3'b010, 7'b1101011, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0001_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0},
        // R1 unknown flavour under funct3 000
        '{5'd1, 7'h7F, 3'b000, 7'b1000000, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 64'h0, 1'b0, 1'b1},
        // R1 pair form with funct7[1]=0
        '{5'd1, 7'h7F, 3'b010, 7'b1111000, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 64'h0, 1'b0, 1'b1},
        // R1 unsupported funct3
        '{5'd1, 7'h7F, 3'b001, 7'b0100000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b1},
        // R1 wrong major opcode
        '{5'd1, 7'h33, 3'b000, 7'b0100000, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 64'h0, 1'b0, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [6:0]      opcode = '0;
    logic [2:0]      funct3 = '0;
    logic [6:0]      funct7 = '0;
    logic [XLEN-1:0] src_a = '0;
    logic [XLEN-1:0] src_b = '0;
    logic            res_valid;
    logic [XLEN-1:0] result;
    logic            sat_set;
    logic            illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd16_addsub #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .opcode(opcode), .funct3(funct3), .funct7(funct7),
        .src_a(src_a), .src_b(src_b),
        .res_valid(res_valid), .result(result),
        .sat_set(sat_set), .illegal(illegal)
    );

    task automatic check(input int req, input logic [66:0] act, input logic [66:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: {valid,result,sat,ill} actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            finish_run();
        end
    end

    initial begin
        logic [XLEN-1:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(11, {res_valid, result, sat_set, illegal}, 67'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_valid = 1'b1;
            opcode = VECS[i].opc;
            funct3 = VECS[i].f3;
            funct7 = VECS[i].f7;
            src_a  = VECS[i].a;
            src_b  = VECS[i].b;
            @(negedge clk);
            op_valid = 1'b0;
            check(int'(VECS[i].req), {res_valid, result, sat_set, illegal},
                  {1'b1, VECS[i].exp, VECS[i].sat, VECS[i].ill});
        end

        // R10: saturating op then idle; pulse drops, result holds
        op_valid = 1'b1; opcode = 7'h7F; funct3 = 3'b000; funct7 = 7'b0011000;
        src_a = 64'hFFFF_0000_0000_0001; src_b = 64'h0001_0000_0000_0001;
        @(negedge clk);
        op_valid = 1'b0;
        src_a = 64'h0; src_b = 64'h0;
        check(10, {res_valid, result, sat_set, illegal}, {1'b1, 64'hFFFF_0000_0000_0002, 1'b1, 1'b0});
        held = result;
        @(negedge clk);
        check(10, {res_valid, result, sat_set, illegal}, {1'b0, held, 1'b0, 1'b0});
        @(negedge clk);
        check(10, {res_valid, result, sat_set, illegal}, {1'b0, held, 1'b0, 1'b0});

        // R11: reset clears a loaded result
        rst_n = 1'b0;
        @(negedge clk);
        check(11, {res_valid, result, sat_set, illegal}, 67'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end
endmodule